// File: doc/BRIEF.md
# Two-Channel Cosine Tone Synthesizer

This block is a direct digital synthesis tone source. A single 16-bit phase accumulator advances by a programmable frequency step on each tick of a clock prescaler, and its upper eight bits address an internal cosine table of signed samples. The prescaler and the step are shared, so the tone frequency is f_clk / (div + 1) × step / 65536 for every channel.

Each channel has its own conditioning path. The shared sample is shifted right arithmetically by a 2-bit amplitude code. An 8-bit DC offset is then added, wrapping modulo 256. Last, one of four bit-inversion patterns is applied. The MSB-flip pattern converts the signed waveform into offset-binary codes suitable for a unipolar DAC. A global enable starts and stops the whole generator. A per-channel enable connects the tone to that channel's output. All settings are static inputs, and a strobe marks each cycle in which fresh codes appear.

Top module: `dds_tone_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, every DAC code is 0x00 and the strobe is low. The phase accumulator clears only on reset.
- R2: With the global enable held high, successive strobe pulses are exactly div + 1 clock cycles apart, where div is the 3-bit divider value 0..7.
- R3: The n-th update after reset uses phase n × step (mod 65536). The sample is round(127 × cos(2π k / 256)) as signed 8-bit, where k is the upper 8 bits of that phase.
- R4: The scale code s (0..3) shifts the signed sample arithmetically right by s bits: 0 is full, 1 is half, 2 is quarter, 3 is one eighth.
- R5: The channel offset (0x00..0xFF) is added to the scaled sample modulo 256, with no saturation.
- R6: The invert code is applied last. 0 leaves the code unchanged, 1 inverts all bits, 2 inverts bit 7 only, and 3 inverts bits 6..0 only.
- R7: DAC codes are registered. They change only in the cycle where the strobe is high, or when the generator is disabled.
- R8: A channel whose enable is low outputs 0x00 at each update. The other channel is unaffected.
- R9: While the global enable is low, both codes are 0x00 from the next cycle on and no strobe occurs. The prescaler and accumulator hold their state, and on re-enable the sample sequence continues where it stopped.
- R10: Both channels use the same phase but their own scale, offset and invert settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_en_i | input | 1 | Global generator enable |
| div_sel_i | input | 3 | Prescaler setting, rate = clk / (value + 1) |
| fstep_i | input | 16 | Phase increment per tick |
| chan_en_i | input | 2 | Per-channel output connect |
| scale_i | input | 2x2 | Per-channel amplitude shift code |
| offset_i | input | 2x8 | Per-channel DC offset |
| invert_i | input | 2x2 | Per-channel inversion pattern |
| dac_o | output | 2x8 | Per-channel DAC code |
| tick_o | output | 1 | High in the cycle new codes appear |

## Verification
A corrupted accumulator or a misaddressed table shows up at the very next strobe as a wrong code on both channels at once. Every later update also stays off, because the phase error persists until reset. A prescaler fault shows at the ports as a wrong gap between strobes, within one divided period. A fault in one channel's conditioning shows on that channel alone, at the first sample whose bits touch the faulty shift, carry or inversion. A halt fault shows as a skipped or repeated sample right after re-enable.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_MSB  = 2'd2,
    INV_LOW  = 2'd3
  } inv_mode_e;
endpackage

// File: rtl/dds_prescaler.sv
module dds_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (cnt_q >= div_i) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (cnt_q >= div_i);
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PH_W = 16,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_i,
  input  logic [PH_W-1:0] step_i,
  output logic [AW-1:0]   addr_nxt_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;

  assign phase_nxt  = phase_q + step_i;
  assign addr_nxt_o = phase_nxt[PH_W-1 -: AW];

  always_ff @(posedge clk) begin
    if (rst)        phase_q <= '0;
    else if (adv_i) phase_q <= phase_nxt;
  end
endmodule

// File: rtl/dds_cos_rom.sv
module dds_cos_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        addr_i,
  output logic signed [DW-1:0] data_o
);
  localparam int  DEPTH = 1 << AW;
  localparam real AMP   = real'((1 << (DW - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [DW-1:0] mem [DEPTH];
  logic signed [DW-1:0] data_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real a;
      a = AMP * $cos(TWO_PI * real'(i) / real'(DEPTH));
      mem[i] = DW'($rtoi(a >= 0.0 ? a + 0.5 : a - 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) data_q <= mem[addr_i];
  end

  assign data_o = data_q;
endmodule

// File: rtl/dds_chan_cond.sv
module dds_chan_cond
  import dds_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tone_en_i,
  input  logic                 load_i,
  input  logic                 ch_en_i,
  input  logic [1:0]           scale_i,
  input  logic [DW-1:0]        offset_i,
  input  logic [1:0]           invert_i,
  input  logic signed [DW-1:0] sample_i,
  output logic [DW-1:0]        code_o
);
  logic signed [DW-1:0] shifted;
  logic [DW-1:0]        summed;
  logic [DW-1:0]        flipped;
  logic [DW-1:0]        code_q;

  always_comb begin
    shifted = sample_i >>> scale_i;
    summed  = DW'(shifted) + offset_i;
    unique case (inv_mode_e'(invert_i))
      INV_NONE: flipped = summed;
      INV_ALL:  flipped = ~summed;
      INV_MSB:  flipped = summed ^ {1'b1, {(DW-1){1'b0}}};
      INV_LOW:  flipped = summed ^ {1'b0, {(DW-1){1'b1}}};
      default:  flipped = summed;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !tone_en_i) code_q <= '0;
    else if (load_i)       code_q <= ch_en_i ? flipped : '0;
  end

  assign code_o = code_q;
endmodule

// File: rtl/dds_tone_gen.sv
module dds_tone_gen #(
  parameter int NCH   = 2,
  parameter int DIV_W = 3,
  parameter int PH_W  = 16,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tone_en_i,
  input  logic [DIV_W-1:0]         div_sel_i,
  input  logic [PH_W-1:0]          fstep_i,
  input  logic [NCH-1:0]           chan_en_i,
  input  logic [NCH-1:0][1:0]      scale_i,
  input  logic [NCH-1:0][DW-1:0]   offset_i,
  input  logic [NCH-1:0][1:0]      invert_i,
  output logic [NCH-1:0][DW-1:0]   dac_o,
  output logic                     tick_o
);
  logic                 tick;
  logic                 tick_d;
  logic                 tick_q;
  logic [AW-1:0]        rom_addr;
  logic signed [DW-1:0] sample;

  dds_prescaler #(.DIV_W(DIV_W)) i_presc (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tone_en_i),
    .div_i  (div_sel_i),
    .tick_o (tick)
  );

  dds_phase_acc #(.PH_W(PH_W), .AW(AW)) i_acc (
    .clk        (clk),
    .rst        (rst),
    .adv_i      (tick),
    .step_i     (fstep_i),
    .addr_nxt_o (rom_addr)
  );

  dds_cos_rom #(.AW(AW), .DW(DW)) i_rom (
    .clk     (clk),
    .rd_en_i (tick),
    .addr_i  (rom_addr),
    .data_o  (sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_d <= tick;
      tick_q <= tick_d && tone_en_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dds_chan_cond #(.DW(DW)) i_cond (
      .clk       (clk),
      .rst       (rst),
      .tone_en_i (tone_en_i),
      .load_i    (tick_d),
      .ch_en_i   (chan_en_i[c]),
      .scale_i   (scale_i[c]),
      .offset_i  (offset_i[c]),
      .invert_i  (invert_i[c]),
      .sample_i  (sample),
      .code_o    (dac_o[c])
    );
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/dds_tone_checker.sv
module dds_tone_checker #(
  parameter int NCH   = 2,
  parameter int DIV_W = 3,
  parameter int DW    = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tone_en_i,
  input logic [DIV_W-1:0]       div_sel_i,
  input logic [NCH-1:0]         chan_en_i,
  input logic [NCH-1:0][DW-1:0] dac_o,
  input logic                   tick_o
);
  localparam int GW = DIV_W + 2;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst || !tone_en_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!tick_o && dac_o == '0)); // R1
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && seen_q && tone_en_i) |-> (gap_q == GW'(div_sel_i) + GW'(1))); // R2
  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
    tone_en_i |=> (tick_o || $stable(dac_o))); // R7
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !tone_en_i |=> (dac_o == '0)); // R9
  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tone_en_i |=> !tick_o); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_CH_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
      !chan_en_i[c] |=> (!tick_o || dac_o[c] == '0)); // R8
  end
endmodule

bind dds_tone_gen dds_tone_checker #(.NCH(NCH), .DIV_W(DIV_W), .DW(DW)) i_chk (.*);

// File: tb/test_dds_tone_gen.sv
module test_dds_tone_gen;
  localparam real PI = 3.141592653589793;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tone_en = 1'b0;
  logic [2:0]        div_sel = '0;
  logic [15:0]       fstep = '0;
  logic [1:0]        chan_en = '0;
  logic [1:0][1:0]   scale = '0;
  logic [1:0][7:0]   offset = '0;
  logic [1:0][1:0]   invert = '0;
  logic [1:0][7:0]   dac;
  logic              tick;

  int   n_tests = 0;
  int   n_fail  = 0;
  longint cyc   = 0;
  longint last_tick = 0;
  bit   skip_gap = 1'b1;
  logic [15:0] ref_ph = '0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dds_tone_gen i_dds_tone_gen (
    .clk(clk), .rst(rst), .tone_en_i(tone_en), .div_sel_i(div_sel),
    .fstep_i(fstep), .chan_en_i(chan_en), .scale_i(scale),
    .offset_i(offset), .invert_i(invert), .dac_o(dac), .tick_o(tick)
  );

  function automatic logic [7:0] ref_code(logic [15:0] ph, logic [1:0] sc,
                                          logic [7:0] of, logic [1:0] iv, logic en);
    real a;
    logic signed [7:0] s;
    logic [7:0] x;
    a = 127.0 * $cos(2.0 * PI * real'(ph[15:8]) / 256.0);
    s = 8'($rtoi(a >= 0.0 ? a + 0.5 : a - 0.5));
    s = s >>> sc;
    x = 8'(s) + of;
    case (iv)
      2'd1:    x = ~x;
      2'd2:    x = x ^ 8'h80;
      2'd3:    x = x ^ 8'h7F;
      default: x = x;
    endcase
    return en ? x : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each strobe (R2..R8, R10)
  always @(negedge clk) begin
    if (!rst && tick) begin
      if (!skip_gap)
        check(cyc - last_tick == longint'(div_sel) + 1, "R2", "strobe gap",
              16'(cyc - last_tick), 16'(div_sel + 1));
      skip_gap  = 1'b0;
      last_tick = cyc;
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe", 16'h1, 16'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(dac[0] == e.a, "R3-R6 ch0", "code", {8'h0, dac[0]}, {8'h0, e.a});
        check(dac[1] == e.b, "R10 ch1", "code", {8'h0, dac[1]}, {8'h0, e.b});
      end
    end
  end

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      ref_ph = ref_ph + fstep;
      e.a = ref_code(ref_ph, scale[0], offset[0], invert[0], chan_en[0]);
      e.b = ref_code(ref_ph, scale[1], offset[1], invert[1], chan_en[1]);
      q.push_back(e);
    end
  endtask

  task automatic run_seg(input logic [2:0] dv, input logic [15:0] st,
                         input logic [1:0] en, input logic [1:0] sc0, input logic [1:0] sc1,
                         input logic [7:0] of0, input logic [7:0] of1,
                         input logic [1:0] iv0, input logic [1:0] iv1, input int n);
    rst = 1'b1;
    div_sel = dv; fstep = st; chan_en = en;
    scale[0] = sc0; scale[1] = sc1; offset[0] = of0; offset[1] = of1;
    invert[0] = iv0; invert[1] = iv1; tone_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_ph = '0;
    skip_gap = 1'b1;
    push(n);
    wait (q.size() == 0);
    rst = 1'b1;
  endtask

  initial begin
    tone_en = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset holds outputs at zero even with the generator enabled
    check(dac == '0, "R1", "dac during reset", {dac[1], dac[0]}, 16'h0);
    check(tick == 1'b0, "R1", "strobe during reset", {15'h0, tick}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check(dac == '0, "R1", "dac after reset", {dac[1], dac[0]}, 16'h0);

    // R3: full table sweep, MSB-flip offset-binary, div 0
    run_seg(3'd0, 16'h0100, 2'b11, 2'd0, 2'd0, 8'h00, 8'h00, 2'd2, 2'd2, 260);
    // R4, R5, R6: half/eighth scale, wrapping offsets, none/all inversion
    run_seg(3'd2, 16'h0B37, 2'b11, 2'd1, 2'd3, 8'h10, 8'hF0, 2'd0, 2'd1, 40);
    // R2, R3: maximum divider, step wrap 0xFFFF, low-bit inversion
    run_seg(3'd7, 16'hFFFF, 2'b11, 2'd2, 2'd0, 8'h80, 8'h7F, 2'd3, 2'd2, 20);
    // R8: channel 0 disconnected, channel 1 live
    run_seg(3'd1, 16'h1234, 2'b10, 2'd0, 2'd1, 8'h33, 8'h05, 2'd1, 2'd2, 20);

    // R9: halt and resume continues the sequence
    rst = 1'b1;
    div_sel = 3'd4; fstep = 16'h0123; chan_en = 2'b11;
    scale = '0; offset[0] = 8'h00; offset[1] = 8'h40; invert[0] = 2'd2; invert[1] = 2'd0;
    tone_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; ref_ph = '0; skip_gap = 1'b1;
    push(5);
    wait (q.size() == 0);
    tone_en = 1'b0;
    @(negedge clk);
    check(dac == '0, "R9", "codes while halted", {dac[1], dac[0]}, 16'h0);
    repeat (30) @(negedge clk);
    check(dac == '0, "R9", "codes still halted", {dac[1], dac[0]}, 16'h0);
    skip_gap = 1'b1;
    push(6);
    tone_en = 1'b1;
    wait (q.size() == 0);
    // R7: codes hold between strobes
    begin
      logic [1:0][7:0] held;
      held = dac;
      @(negedge clk);
      check(tick || dac == held, "R7", "hold between strobes", {dac[1], dac[0]}, {held[1], held[0]});
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule